// File: doc/BRIEF.md
# Segment Descriptor Load Checker

This block handles the loading of a selector into one of three classes of segment register: data, stack or code. In real mode, and also when the virtual-8086 flag is set, it takes a shortcut. The cached base becomes the selector shifted left by four, and no checks are made. In protected mode it works through these steps:

- It picks the global or the local descriptor table from selector bit 2.
- It checks the selector's byte offset against that table's limit.
- It fetches the 8-byte descriptor through a single valid/ready read.
- It applies the privilege and type rules for the register class.
- It either fills the descriptor cache outputs or reports a fault. A fault is general protection, stack fault or not-present, and it comes with an error code.

A successful code load also yields a new current privilege level.

The controller is one state machine with five states:

| State | What happens | Next state |
|-------|--------------|------------|
| IDLE | Waits for `start_i`. | REPORT for a real or virtual-8086 load; BOUND for a protected load. |
| BOUND | Checks the table bound and the null-selector rule. | REPORT if either check fails; otherwise FETCH. |
| FETCH | Holds the read request. | JUDGE once `rd_ready_i` is seen. |
| JUDGE | Evaluates the class rules against the captured descriptor. | REPORT, always. |
| REPORT | Pulses `done_o`. | IDLE, always. |

Top module: `seg_load_checker`

## Requirements
- R1: After reset `done_o`, `fault_o` and `rd_valid_o` are 0, and `fault_kind_o`, `err_code_o`, `base_o`, `limit_o`, `attr_o` and `cpl_o` are all 0.
- R2: A load accepted while `prot_i` is 0 or `v86_i` is 1 does not read memory and completes `done_o` one cycle after the start edge. It reports no fault and sets `base_o` to `sel_i` shifted left by 4. It leaves `limit_o` and `attr_o` unchanged. It sets `cpl_o` to 3 if `v86_i` is 1, and to `cpl_i` otherwise.
- R3: In protected mode the descriptor table is chosen by selector bit 2: 1 picks the local table, 0 the global one. The read address is that table's base plus the selector with its low 3 bits cleared.
- R4: If the selector with its low 3 bits cleared exceeds the chosen table's limit, the block faults. The fault is general protection, with the selector as the error code, and no read is made.
- R5: For a stack or code load whose selector bits 15:3 are all 0, the block faults. The fault is general protection, with error code 0, and no read is made.
- R6: A stack load faults in two ways, with the selector as the error code in both cases:
  - It gives general protection if the descriptor is a system type, is executable or is not writable, or if RPL differs from CPL or from DPL.
  - Failing those checks, it gives a stack fault if the descriptor is not present.
- R7: A code load faults in three ways, checked in this order, with the selector as the error code:
  - general protection on a system-type (gate) descriptor;
  - then not-present if the present bit is clear;
  - then general protection if the descriptor is not executable.
- R8: A conforming code segment faults general protection when DPL > CPL. A non-conforming one faults general protection when RPL > CPL or CPL ≠ DPL. A successful code load sets `cpl_o` to the selector RPL. Every other protected completion sets `cpl_o` to `cpl_i`.
- R9: A data load faults in this order, with the selector as the error code:
  - general protection on a system-type descriptor;
  - then general protection if RPL > DPL or CPL > DPL;
  - then not-present if the present bit is clear.
  
  `kind_i` codes: 0 data, 1 stack, 2 code, 3 treated as data.
- R10: On success the outputs are assembled from the descriptor as follows:
  - `base_o` is {bits 63:56, bits 39:16}.
  - `limit_o` is {bits 51:48, bits 15:0}, shifted left by 12 when bit 55 is set.
  - `attr_o` is {bit 54, bits 47:40}.
  
  Inside the access byte, the bit positions are: present 7, DPL 6:5, non-system 4, executable 3, conforming 2, writable 1.
- R11: `fault_kind_o` is 0 for none, 1 for general protection, 2 for stack fault and 3 for not-present. A faulting load leaves `base_o`, `limit_o` and `attr_o` unchanged.
- R12: `rd_valid_o` stays high with a stable `rd_addr_o` until `rd_ready_i` is sampled high, and the descriptor is taken from `rd_data_i` in that cycle. `done_o` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a load (sampled in IDLE) |
| sel_i | input | 16 | Selector to load |
| kind_i | input | 2 | Register class: 0 data, 1 stack, 2 code |
| cpl_i | input | 2 | Current privilege level |
| prot_i | input | 1 | Protected mode enabled |
| v86_i | input | 1 | Virtual-8086 mode |
| gbase_i | input | 32 | Global table base |
| glim_i | input | TLIM_W | Global table limit |
| lbase_i | input | 32 | Local table base |
| llim_i | input | TLIM_W | Local table limit |
| rd_valid_o | output | 1 | Descriptor read request |
| rd_addr_o | output | 32 | Descriptor read address |
| rd_ready_i | input | 1 | Read accepted, data valid |
| rd_data_i | input | 64 | Descriptor data |
| done_o | output | 1 | Load complete pulse |
| fault_o | output | 1 | Load faulted |
| fault_kind_o | output | 2 | Fault class |
| err_code_o | output | 16 | Fault error code |
| base_o | output | 32 | Cached base |
| limit_o | output | 32 | Cached limit |
| attr_o | output | 9 | Cached size bit and access byte |
| cpl_o | output | 2 | Privilege level after the load |

## Verification
Loads are tried in real mode and in virtual-8086 mode to separate the shortcut's base and privilege results from each other. Global and local selectors are tried on and beyond each table's limit, to show both table choice and bound faults. For each class, one descriptor per rule is built to violate exactly that rule: system type, wrong type, the privilege mismatches, and the present bit cleared. This shows that each rule yields its own fault class and error code, and that a faulting load keeps the previous cache contents. Byte and page granularity, and variable read latencies, tell apart limit scaling and handshake holding.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;
    localparam logic [1:0] KIND_DATA  = 2'd0;
    localparam logic [1:0] KIND_STACK = 2'd1;
    localparam logic [1:0] KIND_CODE  = 2'd2;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_GP     = 2'd1,
        FLT_STACK  = 2'd2,
        FLT_ABSENT = 2'd3
    } flt_e;

    typedef struct packed {
        logic       present;
        logic [1:0] dpl;
        logic       nonsys;
        logic       exec;
        logic       conform;
        logic       rw;
        logic       touched;
    } access_t;

    typedef struct packed {
        logic [31:0] base;
        logic [31:0] limit;
        logic        big;
        access_t     acc;
    } desc_t;
endpackage

// File: rtl/seg_desc_unpack.sv
module seg_desc_unpack
    import seg_chk_pkg::*;
#(
    parameter int PAGE_SHIFT = 12
) (
    input  logic [63:0] raw_i,
    output desc_t       desc_o
);
    logic [31:0] lim_bytes;

    always_comb begin
        lim_bytes     = {12'b0, raw_i[51:48], raw_i[15:0]};
        desc_o.base   = {raw_i[63:56], raw_i[39:16]};
        desc_o.limit  = raw_i[55] ? (lim_bytes << PAGE_SHIFT) : lim_bytes;
        desc_o.big    = raw_i[54];
        desc_o.acc    = access_t'(raw_i[47:40]);
    end
endmodule

// File: rtl/seg_rule_eval.sv
module seg_rule_eval
    import seg_chk_pkg::*;
(
    input  logic [1:0]  kind_i,
    input  logic [15:0] sel_i,
    input  logic [1:0]  cpl_i,
    input  access_t     acc_i,
    output flt_e        flt_o,
    output logic [15:0] err_o
);
    logic [1:0] rpl;

    always_comb begin
        rpl   = sel_i[1:0];
        flt_o = FLT_NONE;
        unique case (kind_i)
            KIND_STACK: begin
                if (!acc_i.nonsys || acc_i.exec || !acc_i.rw ||
                    (rpl != cpl_i) || (rpl != acc_i.dpl))
                    flt_o = FLT_GP;
                else if (!acc_i.present)
                    flt_o = FLT_STACK;
            end
            KIND_CODE: begin
                if (!acc_i.nonsys)
                    flt_o = FLT_GP;
                else if (!acc_i.present)
                    flt_o = FLT_ABSENT;
                else if (!acc_i.exec)
                    flt_o = FLT_GP;
                else if (acc_i.conform ? (acc_i.dpl > cpl_i)
                                       : ((rpl > cpl_i) || (cpl_i != acc_i.dpl)))
                    flt_o = FLT_GP;
            end
            default: begin
                if (!acc_i.nonsys)
                    flt_o = FLT_GP;
                else if ((rpl > acc_i.dpl) || (cpl_i > acc_i.dpl))
                    flt_o = FLT_GP;
                else if (!acc_i.present)
                    flt_o = FLT_ABSENT;
            end
        endcase
        err_o = (flt_o == FLT_NONE) ? 16'h0000 : sel_i;
    end
endmodule

// File: rtl/seg_load_checker.sv
module seg_load_checker
    import seg_chk_pkg::*;
#(
    parameter int TLIM_W     = 16,
    parameter int PAGE_SHIFT = 12,
    parameter int REAL_SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [15:0]       sel_i,
    input  logic [1:0]        kind_i,
    input  logic [1:0]        cpl_i,
    input  logic              prot_i,
    input  logic              v86_i,
    input  logic [31:0]       gbase_i,
    input  logic [TLIM_W-1:0] glim_i,
    input  logic [31:0]       lbase_i,
    input  logic [TLIM_W-1:0] llim_i,
    output logic              rd_valid_o,
    output logic [31:0]       rd_addr_o,
    input  logic              rd_ready_i,
    input  logic [63:0]       rd_data_i,
    output logic              done_o,
    output logic              fault_o,
    output logic [1:0]        fault_kind_o,
    output logic [15:0]       err_code_o,
    output logic [31:0]       base_o,
    output logic [31:0]       limit_o,
    output logic [8:0]        attr_o,
    output logic [1:0]        cpl_o
);
    localparam int IDX_LSB = 3;

    typedef enum logic [2:0] {
        ST_IDLE, ST_BOUND, ST_FETCH, ST_JUDGE, ST_REPORT
    } state_e;

    state_e      state_q, state_d;
    logic [15:0] sel_q;
    logic [1:0]  kind_q;
    logic [1:0]  cpl_q;
    logic [63:0] raw_q;

    logic [15:0]       offset;
    logic [TLIM_W-1:0] tab_lim;
    logic              beyond;
    logic              null_bad;
    logic              real_load;
    desc_t             desc;
    flt_e              verdict;
    logic [15:0]       verdict_err;

    always_comb begin
        offset    = {sel_q[15:IDX_LSB], {IDX_LSB{1'b0}}};
        tab_lim   = sel_q[2] ? llim_i : glim_i;
        beyond    = 32'(offset) > 32'(tab_lim);
        null_bad  = (sel_q[15:IDX_LSB] == '0) &&
                    ((kind_q == KIND_STACK) || (kind_q == KIND_CODE));
        real_load = !prot_i || v86_i;
        rd_addr_o = (sel_q[2] ? lbase_i : gbase_i) + 32'(offset);
    end

    seg_desc_unpack #(.PAGE_SHIFT(PAGE_SHIFT)) u_unpack (
        .raw_i  (raw_q),
        .desc_o (desc)
    );

    seg_rule_eval u_rules (
        .kind_i (kind_q),
        .sel_i  (sel_q),
        .cpl_i  (cpl_q),
        .acc_i  (desc.acc),
        .flt_o  (verdict),
        .err_o  (verdict_err)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = real_load ? ST_REPORT : ST_BOUND;
            ST_BOUND:  state_d = (beyond || null_bad) ? ST_REPORT : ST_FETCH;
            ST_FETCH:  if (rd_ready_i) state_d = ST_JUDGE;
            ST_JUDGE:  state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        rd_valid_o = (state_q == ST_FETCH);
        done_o     = (state_q == ST_REPORT);
    end

    // result and capture registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q        <= '0;
            kind_q       <= '0;
            cpl_q        <= '0;
            raw_q        <= '0;
            fault_o      <= 1'b0;
            fault_kind_o <= FLT_NONE;
            err_code_o   <= '0;
            base_o       <= '0;
            limit_o      <= '0;
            attr_o       <= '0;
            cpl_o        <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    sel_q  <= sel_i;
                    kind_q <= kind_i;
                    cpl_q  <= cpl_i;
                    if (real_load) begin
                        fault_o      <= 1'b0;
                        fault_kind_o <= FLT_NONE;
                        err_code_o   <= '0;
                        base_o       <= 32'(sel_i) << REAL_SHIFT;
                        cpl_o        <= v86_i ? 2'd3 : cpl_i;
                    end
                end
                ST_BOUND: if (beyond || null_bad) begin
                    fault_o      <= 1'b1;
                    fault_kind_o <= FLT_GP;
                    err_code_o   <= beyond ? sel_q : 16'h0000;
                    cpl_o        <= cpl_q;
                end
                ST_FETCH: if (rd_ready_i) raw_q <= rd_data_i;
                ST_JUDGE: begin
                    fault_o      <= (verdict != FLT_NONE);
                    fault_kind_o <= verdict;
                    err_code_o   <= verdict_err;
                    cpl_o        <= cpl_q;
                    if (verdict == FLT_NONE) begin
                        base_o  <= desc.base;
                        limit_o <= desc.limit;
                        attr_o  <= {desc.big, desc.acc};
                        if (kind_q == KIND_CODE) cpl_o <= sel_q[1:0];
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

module seg_load_checker_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_valid_o,
    input logic        rd_ready_i,
    input logic [31:0] rd_addr_o,
    input logic        done_o,
    input logic        fault_o,
    input logic [1:0]  fault_kind_o,
    input logic [31:0] base_o,
    input logic [31:0] limit_o,
    input logic [8:0]  attr_o
);
    // R12
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_addr_o)));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11
    fault_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (fault_o == (fault_kind_o != 2'd0)));

    // R11
    keep_cache_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o) |-> ($stable(base_o) && $stable(limit_o) && $stable(attr_o)));

    // R4
    no_read_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !rd_valid_o);
endmodule

bind seg_load_checker seg_load_checker_sva u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_valid_o   (rd_valid_o),
    .rd_ready_i   (rd_ready_i),
    .rd_addr_o    (rd_addr_o),
    .done_o       (done_o),
    .fault_o      (fault_o),
    .fault_kind_o (fault_kind_o),
    .base_o       (base_o),
    .limit_o      (limit_o),
    .attr_o       (attr_o)
);

// File: tb/seg_load_checker_test.sv
module seg_load_checker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] sel_i = '0;
    logic [1:0]  kind_i = '0;
    logic [1:0]  cpl_i = '0;
    logic        prot_i = 1'b0;
    logic        v86_i = 1'b0;
    logic [31:0] gbase_i = 32'h0001_0000;
    logic [15:0] glim_i = 16'h00FF;
    logic [31:0] lbase_i = 32'h0002_0000;
    logic [15:0] llim_i = 16'h001F;
    logic        rd_valid_o;
    logic [31:0] rd_addr_o;
    logic        rd_ready_i = 1'b0;
    logic [63:0] rd_data_i = '0;
    logic        done_o, fault_o;
    logic [1:0]  fault_kind_o, cpl_o;
    logic [15:0] err_code_o;
    logic [31:0] base_o, limit_o;
    logic [8:0]  attr_o;

    seg_load_checker uut (.*);

    always #2 clk = ~clk;

    typedef struct {
        logic        fault;
        logic [1:0]  kind;
        logic [15:0] err;
        logic [31:0] base;
        logic [31:0] limit;
        logic [8:0]  attr;
        logic [1:0]  cpl;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    int          n_vec = 0;
    int          n_bad = 0;
    logic [31:0] m_base = '0;
    logic [31:0] m_limit = '0;
    logic [8:0]  m_attr = '0;

    function automatic logic [63:0] mk(input logic [31:0] b, input logic [19:0] l,
                                       input logic [7:0] acc, input logic g, input logic d);
        return {b[31:24], g, d, 2'b00, l[19:16], acc, b[23:0], l[15:0]};
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            exp_t e;
            n_vec++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected done: fault=%0d expected no completion", fault_o);
            end else begin
                e = exp_q.pop_front();
                if (fault_o !== e.fault || fault_kind_o !== e.kind || err_code_o !== e.err ||
                    base_o !== e.base || limit_o !== e.limit || attr_o !== e.attr ||
                    cpl_o !== e.cpl) begin
                    n_bad++;
                    $display("FAIL %s: got f=%0d k=%0d err=%h base=%h lim=%h attr=%h cpl=%0d exp f=%0d k=%0d err=%h base=%h lim=%h attr=%h cpl=%0d",
                        e.tag, fault_o, fault_kind_o, err_code_o, base_o, limit_o, attr_o, cpl_o,
                        e.fault, e.kind, e.err, e.base, e.limit, e.attr, e.cpl);
                end
            end
        end
    end

    task automatic load(input logic [15:0] sel, input logic [1:0] kind, input logic [1:0] cpl,
                        input logic prot, input logic v86, input logic [63:0] desc,
                        input int gap, input string tag);
        exp_t        e;
        logic        want_read = 1'b0;
        logic [31:0] want_addr = '0;
        logic [15:0] off = sel & 16'hFFF8;
        logic [15:0] tl = sel[2] ? llim_i : glim_i;
        logic [1:0]  rpl = sel[1:0];
        logic        p = desc[47], s = desc[44], x = desc[43], c = desc[42], w = desc[41];
        logic [1:0]  dpl = desc[46:45];
        logic        served = 1'b0;
        e.tag = tag; e.fault = 1'b0; e.kind = 2'd0; e.err = 16'h0; e.cpl = cpl;
        if (!prot || v86) begin
            m_base = {12'h000, sel, 4'h0};
            if (v86) e.cpl = 2'd3;
        end else if (off > tl) begin
            e.fault = 1'b1; e.kind = 2'd1; e.err = sel;
        end else if ((kind == 2'd1 || kind == 2'd2) && off == 16'h0) begin
            e.fault = 1'b1; e.kind = 2'd1; e.err = 16'h0;
        end else begin
            want_read = 1'b1;
            want_addr = (sel[2] ? lbase_i : gbase_i) + {16'h0, off};
            if (kind == 2'd1) begin
                if (!s || x || !w || rpl != cpl || rpl != dpl) e.kind = 2'd1;
                else if (!p) e.kind = 2'd2;
            end else if (kind == 2'd2) begin
                if (!s) e.kind = 2'd1;
                else if (!p) e.kind = 2'd3;
                else if (!x) e.kind = 2'd1;
                else if (c && dpl > cpl) e.kind = 2'd1;
                else if (!c && (rpl > cpl || cpl != dpl)) e.kind = 2'd1;
            end else begin
                if (!s || rpl > dpl || cpl > dpl) e.kind = 2'd1;
                else if (!p) e.kind = 2'd3;
            end
            if (e.kind != 2'd0) begin
                e.fault = 1'b1; e.err = sel;
            end else begin
                m_base  = {desc[63:56], desc[39:16]};
                m_limit = {12'h0, desc[51:48], desc[15:0]};
                if (desc[55]) m_limit = {m_limit[19:0], 12'h000};
                m_attr  = {desc[54], desc[47:40]};
                if (kind == 2'd2) e.cpl = rpl;
            end
        end
        e.base = m_base; e.limit = m_limit; e.attr = m_attr;
        exp_q.push_back(e);

        @(negedge clk);
        sel_i = sel; kind_i = kind; cpl_i = cpl; prot_i = prot; v86_i = v86; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        forever begin
            if (done_o) break;
            if (rd_valid_o && !served) begin
                n_vec++;
                if (!want_read || rd_addr_o !== want_addr) begin
                    n_bad++;
                    $display("FAIL %s R3 read: got req addr=%h expected read=%0d addr=%h",
                             tag, rd_addr_o, want_read, want_addr);
                end
                repeat (gap) @(negedge clk);
                rd_ready_i = 1'b1; rd_data_i = desc;
                @(negedge clk);
                rd_ready_i = 1'b0;
                served = 1'b1;
            end else begin
                @(negedge clk);
            end
        end
        if (want_read && !served) begin
            n_vec++; n_bad++;
            $display("FAIL %s R3 read: got no request expected addr=%h", tag, want_addr);
        end
        @(negedge clk);
    endtask

    logic finished = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        n_vec++;
        if (done_o !== 1'b0 || fault_o !== 1'b0 || rd_valid_o !== 1'b0 || fault_kind_o !== 2'd0 ||
            err_code_o !== 16'h0 || base_o !== 32'h0 || limit_o !== 32'h0 || attr_o !== 9'h0 ||
            cpl_o !== 2'd0) begin
            n_bad++;
            $display("FAIL R1 reset: got done=%0d fault=%0d base=%h lim=%h attr=%h expected all 0",
                     done_o, fault_o, base_o, limit_o, attr_o);
        end
        // R2 real mode and virtual-8086 shortcut
        load(16'h1234, 2'd0, 2'd0, 1'b0, 1'b0, 64'h0, 0, "R2 real");
        load(16'hB800, 2'd2, 2'd0, 1'b1, 1'b1, 64'h0, 0, "R2 v86");
        // R3 R9 R10 global and local data loads, granularity
        load(16'h0010, 2'd0, 2'd0, 1'b1, 1'b0, mk(32'h1234_5678, 20'h0FFFF, 8'h92, 1'b0, 1'b1), 0, "R10 data byte gran");
        load(16'h001B, 2'd0, 2'd3, 1'b1, 1'b0, mk(32'h0, 20'hFFFFF, 8'hF2, 1'b1, 1'b0), 2, "R10 page gran");
        load(16'h000C, 2'd0, 2'd0, 1'b1, 1'b0, mk(32'h0040_0000, 20'h00100, 8'h92, 1'b0, 1'b0), 1, "R3 local table");
        load(16'h00F8, 2'd0, 2'd0, 1'b1, 1'b0, mk(32'hA000_0000, 20'h00FFF, 8'h92, 1'b0, 1'b0), 3, "R3 last global entry");
        // R4 bound faults
        load(16'h0100, 2'd0, 2'd0, 1'b1, 1'b0, 64'h0, 0, "R4 global beyond");
        load(16'h0024, 2'd1, 2'd0, 1'b1, 1'b0, 64'h0, 0, "R4 local beyond");
        // R5 null selectors
        load(16'h0000, 2'd1, 2'd0, 1'b1, 1'b0, 64'h0, 0, "R5 null stack");
        load(16'h0004, 2'd2, 2'd0, 1'b1, 1'b0, 64'h0, 0, "R5 null code");
        // R6 stack rules
        load(16'h0010, 2'd1, 2'd0, 1'b1, 1'b0, mk(32'h0008_0000, 20'h0FFFF, 8'h92, 1'b0, 1'b1), 1, "R6 stack ok");
        load(16'h0010, 2'd1, 2'd0, 1'b1, 1'b0, mk(32'h1, 20'h1, 8'h90, 1'b0, 1'b0), 0, "R6 stack read-only");
        load(16'h0013, 2'd1, 2'd0, 1'b1, 1'b0, mk(32'h1, 20'h1, 8'hF2, 1'b0, 1'b0), 0, "R6 stack rpl");
        load(16'h0010, 2'd1, 2'd0, 1'b1, 1'b0, mk(32'h1, 20'h1, 8'h9A, 1'b0, 1'b0), 0, "R6 stack exec");
        load(16'h0010, 2'd1, 2'd0, 1'b1, 1'b0, mk(32'h1, 20'h1, 8'h12, 1'b0, 1'b0), 0, "R6 stack absent");
        // R7 code type and presence
        load(16'h0008, 2'd2, 2'd0, 1'b1, 1'b0, mk(32'h1, 20'h1, 8'h1A, 1'b0, 1'b0), 0, "R7 code absent");
        load(16'h0008, 2'd2, 2'd0, 1'b1, 1'b0, mk(32'h1, 20'h1, 8'h92, 1'b0, 1'b0), 0, "R7 code not exec");
        load(16'h0008, 2'd2, 2'd0, 1'b1, 1'b0, mk(32'h1, 20'h1, 8'h82, 1'b0, 1'b0), 0, "R7 code system");
        // R8 code privilege
        load(16'h0008, 2'd2, 2'd0, 1'b1, 1'b0, mk(32'h0010_0000, 20'h0FFFF, 8'h9A, 1'b0, 1'b1), 0, "R8 nonconf ok");
        load(16'h000B, 2'd2, 2'd2, 1'b1, 1'b0, mk(32'h0020_0000, 20'h00FFF, 8'h9E, 1'b0, 1'b0), 2, "R8 conf cpl update");
        load(16'h0008, 2'd2, 2'd0, 1'b1, 1'b0, mk(32'h1, 20'h1, 8'hFE, 1'b0, 1'b0), 0, "R8 conf dpl>cpl");
        load(16'h000B, 2'd2, 2'd0, 1'b1, 1'b0, mk(32'h1, 20'h1, 8'h9A, 1'b0, 1'b0), 0, "R8 nonconf rpl>cpl");
        load(16'h000B, 2'd2, 2'd3, 1'b1, 1'b0, mk(32'h1, 20'h1, 8'h9A, 1'b0, 1'b0), 0, "R8 nonconf cpl!=dpl");
        // R9 data rules
        load(16'h0013, 2'd0, 2'd0, 1'b1, 1'b0, mk(32'h1, 20'h1, 8'h92, 1'b0, 1'b0), 0, "R9 data rpl>dpl");
        load(16'h0010, 2'd0, 2'd3, 1'b1, 1'b0, mk(32'h1, 20'h1, 8'h92, 1'b0, 1'b0), 0, "R9 data cpl>dpl");
        load(16'h0010, 2'd3, 2'd0, 1'b1, 1'b0, mk(32'h1, 20'h1, 8'h82, 1'b0, 1'b0), 0, "R9 data system");
        load(16'h0010, 2'd0, 2'd0, 1'b1, 1'b0, mk(32'h1, 20'h1, 8'h12, 1'b0, 1'b0), 0, "R9 data absent");
        // R11 R12 real load after faults keeps limit/attr
        load(16'hFFFF, 2'd0, 2'd1, 1'b0, 1'b0, 64'h0, 0, "R11 real after fault");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_vec++; n_bad++;
            $display("FAIL R12 completions: got %0d missing expected 0", exp_q.size());
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule